// File: doc/BRIEF.md
# Selectable Serial Line Coder with Matching Decoder

This block sits between a packet serializer and a modulator. On the transmit side it takes one data bit per handshake and turns it into line chips. Four independent configuration bits select the stages: a self-synchronizing multiplicative scrambler, differential coding, polarity inversion and Manchester coding. The stages always run in the same order: scramble, then differential, then invert, then Manchester. On the receive side the inverse chain turns chips back into data bits. That chain is Manchester pairing, un-inversion, differential decoding and descrambling. Manchester pairs that are not complementary are flagged.

The scrambler uses the polynomial 1 + x^12 + x^17. The transmit side feeds back its own scrambled output history. The receive side uses the history of the chips it received, so a receiver recovers by itself after a line error. Configuration is expected to change only while reset is asserted.

Encoder states: `ENC_TAKE` (ready high; a bit is accepted and its first chip is produced) and `ENC_SECOND` (ready low; the complement chip is produced). Transitions: `ENC_TAKE -> ENC_SECOND` on an accepted bit with Manchester on; `ENC_SECOND -> ENC_TAKE` always. Decoder states: `DEC_FIRST` (waiting for a symbol's first chip) and `DEC_SECOND` (first Manchester chip held). Transitions: `DEC_FIRST -> DEC_SECOND` on a valid chip with Manchester on; `DEC_SECOND -> DEC_FIRST` on the next valid chip.

Top module: `line_coder_top`

## Requirements
- R1: While reset is asserted, and after it is released, `tx_chip_valid`, `rx_bit_valid` and `rx_violation` are 0 and `tx_bit_ready` is 1. Reset clears both scrambler histories and both differential levels to 0.
- R2: With `cfg_scramble`=1, the scrambled bit is s[n] = b[n] xor s[n-12] xor s[n-17], where s[] is the encoder's own scrambled history and terms before the first bit after reset are 0. With `cfg_scramble`=0, s[n] = b[n].
- R3: With `cfg_diff`=1, the line level toggles for a 1 and holds for a 0, starting from level 0. With `cfg_diff`=0, the bit passes unchanged.
- R4: With `cfg_invert`=1, every coded bit is complemented before Manchester coding.
- R5: With `cfg_manch`=1, each coded bit c is sent as chip c followed by chip not c (1 becomes 10, 0 becomes 01). `tx_bit_ready` is 0 in the cycle after an accepted bit.
- R6: The stages apply in the order scramble, differential, invert, Manchester. The first chip of an accepted bit appears on `tx_chip` with `tx_chip_valid` in the cycle after acceptance, and no chip appears otherwise.
- R7: For all 16 configurations, feeding the chip stream back into the receive side reproduces the sent bits in order, with `rx_violation`=0. Each bit appears one cycle after the last chip of its symbol.
- R8: With `cfg_manch`=1, a received pair 00 or 11 raises `rx_violation` together with `rx_bit_valid`, and the decoded bit is the pair's first chip passed through the remaining inverse stages. A pair 10 or 01 gives `rx_violation`=0. With `cfg_manch`=0, `rx_violation` stays 0.
- R9: With only Manchester on, inverting every received chip complements every decoded bit.
- R10: With only differential on, inverting every received chip corrupts only the first decoded bit.
- R11: With only scrambling on, a single corrupted chip at bit position k corrupts exactly the decoded bits k, k+12 and k+17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_scramble | input | 1 | Enable scrambler and descrambler |
| cfg_diff | input | 1 | Enable differential coding |
| cfg_invert | input | 1 | Enable polarity inversion |
| cfg_manch | input | 1 | Enable Manchester coding |
| tx_bit_valid | input | 1 | Transmit data bit offered |
| tx_bit | input | 1 | Transmit data bit |
| tx_bit_ready | output | 1 | Encoder accepts a bit this cycle |
| tx_chip_valid | output | 1 | Line chip present |
| tx_chip | output | 1 | Line chip |
| rx_chip_valid | input | 1 | Received chip present |
| rx_chip | input | 1 | Received chip |
| rx_bit_valid | output | 1 | Decoded bit present |
| rx_bit | output | 1 | Decoded bit |
| rx_violation | output | 1 | Manchester pair was 00 or 11 |

## Verification
Every one of the 16 configurations is run with a pseudo-random bit stream. Each emitted chip is compared against an arithmetic model of the transmit chain, and the looped-back decoded bits are compared against the sent bits. Each single stage is also run on its own with all-ones and alternating patterns: all-ones exercises the scrambler feedback and the differential toggling, and alternating bits tell an inversion apart from a level hold. Deliberately inverted or single-chip-corrupted loopbacks separate the Manchester polarity, differential inversion immunity and scrambler error multiplication. Hand-driven 00, 11 and 10 pairs exercise the violation flag.

// File: rtl/lc_pkg.sv
package lc_pkg;
    typedef enum logic {ENC_TAKE, ENC_SECOND} enc_state_e;
    typedef enum logic {DEC_FIRST, DEC_SECOND} dec_state_e;
    localparam int SCR_TAP_NEAR = 12;
    localparam int SCR_TAP_FAR  = 17;
endpackage

// File: rtl/lc_scrambler.sv
module lc_scrambler #(
    parameter int TAP_NEAR   = 12,
    parameter int TAP_FAR    = 17,
    parameter bit DESCRAMBLE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic step,
    input  logic din,
    output logic dout
);
    localparam int HIST = TAP_FAR;

    logic [HIST-1:0] hist;
    logic            feedback;
    logic            hist_in;

    assign feedback = hist[TAP_NEAR-1] ^ hist[TAP_FAR-1];
    assign dout     = en ? (din ^ feedback) : din;

    generate
        if (DESCRAMBLE) begin : g_rx
            assign hist_in = din;
        end else begin : g_tx
            assign hist_in = dout;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (step) begin
            hist <= {hist[HIST-2:0], hist_in};
        end
    end
endmodule

// File: rtl/lc_encoder.sv
module lc_encoder
    import lc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_scramble,
    input  logic cfg_diff,
    input  logic cfg_invert,
    input  logic cfg_manch,
    input  logic in_valid,
    input  logic in_bit,
    output logic in_ready,
    output logic chip_valid,
    output logic chip
);
    enc_state_e state, state_nx;
    logic accept;
    logic scr_bit;
    logic diff_bit;
    logic line_bit;
    logic level;

    assign in_ready = (state == ENC_TAKE);
    assign accept   = in_valid && in_ready;

    lc_scrambler #(
        .TAP_NEAR  (SCR_TAP_NEAR),
        .TAP_FAR   (SCR_TAP_FAR),
        .DESCRAMBLE(1'b0)
    ) u_scr (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (cfg_scramble),
        .step (accept),
        .din  (in_bit),
        .dout (scr_bit)
    );

    assign diff_bit = cfg_diff ? (level ^ scr_bit) : scr_bit;
    assign line_bit = diff_bit ^ cfg_invert;

    always_comb begin
        state_nx = state;
        unique case (state)
            ENC_TAKE:   if (accept && cfg_manch) state_nx = ENC_SECOND;
            ENC_SECOND: state_nx = ENC_TAKE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ENC_TAKE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chip_valid <= 1'b0;
            chip       <= 1'b0;
            level      <= 1'b0;
        end else begin
            chip_valid <= 1'b0;
            if (accept) begin
                chip_valid <= 1'b1;
                chip       <= line_bit;
                if (cfg_diff) level <= diff_bit;
            end else if (state == ENC_SECOND) begin
                chip_valid <= 1'b1;
                chip       <= ~chip;
            end
        end
    end
endmodule

// File: rtl/lc_decoder.sv
module lc_decoder
    import lc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_scramble,
    input  logic cfg_diff,
    input  logic cfg_invert,
    input  logic cfg_manch,
    input  logic chip_valid,
    input  logic chip,
    output logic bit_valid,
    output logic bit_out,
    output logic violation
);
    dec_state_e state, state_nx;
    logic first_q;
    logic produce;
    logic sym;
    logic unv_bit;
    logic undiff_bit;
    logic plain_bit;
    logic prev_level;

    assign produce    = chip_valid && (!cfg_manch || state == DEC_SECOND);
    assign sym        = cfg_manch ? first_q : chip;
    assign unv_bit    = sym ^ cfg_invert;
    assign undiff_bit = cfg_diff ? (unv_bit ^ prev_level) : unv_bit;

    lc_scrambler #(
        .TAP_NEAR  (SCR_TAP_NEAR),
        .TAP_FAR   (SCR_TAP_FAR),
        .DESCRAMBLE(1'b1)
    ) u_descr (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (cfg_scramble),
        .step (produce),
        .din  (undiff_bit),
        .dout (plain_bit)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            DEC_FIRST:  if (chip_valid && cfg_manch) state_nx = DEC_SECOND;
            DEC_SECOND: if (chip_valid) state_nx = DEC_FIRST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= DEC_FIRST;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_valid  <= 1'b0;
            bit_out    <= 1'b0;
            violation  <= 1'b0;
            first_q    <= 1'b0;
            prev_level <= 1'b0;
        end else begin
            bit_valid <= 1'b0;
            violation <= 1'b0;
            if (state == DEC_FIRST && chip_valid && cfg_manch) begin
                first_q <= chip;
            end
            if (produce) begin
                bit_valid <= 1'b1;
                bit_out   <= plain_bit;
                violation <= cfg_manch && (first_q == chip);
                if (cfg_diff) prev_level <= unv_bit;
            end
        end
    end
endmodule

// File: rtl/line_coder_top.sv
module line_coder_top (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_scramble,
    input  logic cfg_diff,
    input  logic cfg_invert,
    input  logic cfg_manch,
    input  logic tx_bit_valid,
    input  logic tx_bit,
    output logic tx_bit_ready,
    output logic tx_chip_valid,
    output logic tx_chip,
    input  logic rx_chip_valid,
    input  logic rx_chip,
    output logic rx_bit_valid,
    output logic rx_bit,
    output logic rx_violation
);
    lc_encoder u_enc (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_scramble(cfg_scramble),
        .cfg_diff    (cfg_diff),
        .cfg_invert  (cfg_invert),
        .cfg_manch   (cfg_manch),
        .in_valid    (tx_bit_valid),
        .in_bit      (tx_bit),
        .in_ready    (tx_bit_ready),
        .chip_valid  (tx_chip_valid),
        .chip        (tx_chip)
    );

    lc_decoder u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_scramble(cfg_scramble),
        .cfg_diff    (cfg_diff),
        .cfg_invert  (cfg_invert),
        .cfg_manch   (cfg_manch),
        .chip_valid  (rx_chip_valid),
        .chip        (rx_chip),
        .bit_valid   (rx_bit_valid),
        .bit_out     (rx_bit),
        .violation   (rx_violation)
    );
endmodule

// File: rtl/lc_checker.sv
module lc_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_manch,
    input logic tx_bit_valid,
    input logic tx_bit_ready,
    input logic tx_chip_valid,
    input logic tx_chip,
    input logic rx_bit_valid,
    input logic rx_violation
);
    assert_ready_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_manch && tx_bit_valid && tx_bit_ready) |=> !tx_bit_ready);

    assert_pair_complement_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_manch && tx_bit_valid && tx_bit_ready) |=> ##1 (tx_chip_valid && (tx_chip != $past(tx_chip))));

    assert_chip_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_bit_valid && tx_bit_ready) |=> tx_chip_valid);

    assert_no_stray_chip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_manch && !(tx_bit_valid && tx_bit_ready)) |=> !tx_chip_valid);

    assert_violation_needs_manch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_manch |-> !rx_violation);

    assert_violation_with_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_violation |-> rx_bit_valid);
endmodule

bind line_coder_top lc_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_manch    (cfg_manch),
    .tx_bit_valid (tx_bit_valid),
    .tx_bit_ready (tx_bit_ready),
    .tx_chip_valid(tx_chip_valid),
    .tx_chip      (tx_chip),
    .rx_bit_valid (rx_bit_valid),
    .rx_violation (rx_violation)
);

// File: tb/line_coder_top_tb.sv
`timescale 1ns/1ps
module line_coder_top_tb;
    localparam int N = 48;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic cfg_scramble = 0, cfg_diff = 0, cfg_invert = 0, cfg_manch = 0;
    logic tx_bit_valid = 0, tx_bit = 0;
    logic tx_bit_ready, tx_chip_valid, tx_chip;
    logic rx_chip_valid, rx_chip;
    logic rx_bit_valid, rx_bit, rx_violation;

    logic lb_en = 1'b1;
    int   flip_mode = 0;
    int   chip_cnt = 0;
    logic drv_valid = 0, drv_chip = 0;
    logic flip;

    assign flip = (flip_mode == 1) || (flip_mode == 2 && chip_cnt == 20);
    assign rx_chip_valid = lb_en ? tx_chip_valid : drv_valid;
    assign rx_chip       = lb_en ? (tx_chip ^ flip) : drv_chip;

    always @(posedge clk) begin
        if (!rst_n) chip_cnt <= 0;
        else if (tx_chip_valid) chip_cnt <= chip_cnt + 1;
    end

    line_coder_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_scramble(cfg_scramble), .cfg_diff(cfg_diff),
        .cfg_invert(cfg_invert), .cfg_manch(cfg_manch),
        .tx_bit_valid(tx_bit_valid), .tx_bit(tx_bit), .tx_bit_ready(tx_bit_ready),
        .tx_chip_valid(tx_chip_valid), .tx_chip(tx_chip),
        .rx_chip_valid(rx_chip_valid), .rx_chip(rx_chip),
        .rx_bit_valid(rx_bit_valid), .rx_bit(rx_bit), .rx_violation(rx_violation)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [N-1:0]   dat;
    logic [N-1:0]   expr;
    logic [2*N-1:0] expc;
    int nexp;
    int ci, ri;
    bit mon_en = 0;
    string tag = "R1";

    task automatic chk(input bit ok, input string t, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    // Chain monitor: chips against the model, decoded bits against sent data
    always @(negedge clk) begin
        if (mon_en) begin
            if (tx_chip_valid) begin
                if (ci < nexp) chk(tx_chip === expc[ci], tag, int'(tx_chip), int'(expc[ci]));
                else chk(1'b0, tag, ci, nexp);
                ci++;
            end
            if (rx_bit_valid) begin
                if (ri < N) chk(rx_bit === expr[ri], tag, int'(rx_bit), int'(expr[ri]));
                else chk(1'b0, tag, ri, N);
                chk(rx_violation === 1'b0, tag, int'(rx_violation), 0);
                ri++;
            end
        end
    end

    // Arithmetic model of the transmit chain
    task automatic build_model();
        logic [N-1:0] s;
        logic lvl;
        lvl  = 1'b0;
        nexp = 0;
        expc = '0;
        for (int n = 0; n < N; n++) begin
            logic d, c;
            s[n] = dat[n];
            if (cfg_scramble) begin
                if (n >= 12) s[n] = s[n] ^ s[n-12];
                if (n >= 17) s[n] = s[n] ^ s[n-17];
            end
            d = cfg_diff ? (lvl ^ s[n]) : s[n];
            if (cfg_diff) lvl = d;
            c = d ^ cfg_invert;
            expc[nexp] = c; nexp++;
            if (cfg_manch) begin
                expc[nexp] = ~c; nexp++;
            end
        end
    endtask

    task automatic do_reset();
        mon_en = 0;
        tx_bit_valid = 0;
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic run_case(input logic [3:0] cfg, input int pat, input int seed,
                            input int fm, input string t);
        int unsigned x;
        int idx;
        bit prev_acc;
        mon_en = 0;
        @(negedge clk); rst_n = 0;
        {cfg_manch, cfg_invert, cfg_diff, cfg_scramble} = cfg;
        lb_en = 1; flip_mode = fm; tag = t;
        x = seed;
        for (int i = 0; i < N; i++) begin
            x = x * 1103515245 + 12345;
            case (pat)
                0: dat[i] = x[16];
                1: dat[i] = 1'b1;
                default: dat[i] = i[0];
            endcase
        end
        build_model();
        expr = dat;
        if (fm == 1) begin
            if (cfg_manch) expr = ~dat;
            else expr[0] = ~dat[0];
        end else if (fm == 2) begin
            expr[20] = ~dat[20]; expr[32] = ~dat[32]; expr[37] = ~dat[37];
        end
        repeat (2) @(negedge clk);
        rst_n = 1; ci = 0; ri = 0; mon_en = 1;
        idx = 0; prev_acc = 0;
        while (idx < N) begin
            bit rdy;
            @(negedge clk);
            rdy = tx_bit_ready;
            if (prev_acc && cfg_manch) chk(rdy == 1'b0, "R5", int'(rdy), 0);
            tx_bit_valid = 1; tx_bit = dat[idx];
            @(posedge clk);
            prev_acc = rdy;
            if (rdy) idx++;
        end
        @(negedge clk); tx_bit_valid = 0;
        repeat (6) @(negedge clk);
        chk(ci == nexp, t, ci, nexp);
        chk(ri == N, t, ri, N);
        mon_en = 0;
    endtask

    task automatic drive_pair(input logic a, input logic b, input logic eb, input logic ev);
        @(negedge clk); drv_valid = 1; drv_chip = a;
        @(negedge clk); drv_chip = b;
        @(negedge clk); drv_valid = 0;
        chk(rx_bit_valid === 1'b1, "R8", int'(rx_bit_valid), 1);
        chk(rx_bit === eb, "R8", int'(rx_bit), int'(eb));
        chk(rx_violation === ev, "R8", int'(rx_violation), int'(ev));
        @(negedge clk);
        chk(rx_bit_valid === 1'b0, "R8", int'(rx_bit_valid), 0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R7 watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(tx_chip_valid === 1'b0, "R1", int'(tx_chip_valid), 0);
        chk(rx_bit_valid === 1'b0, "R1", int'(rx_bit_valid), 0);
        rst_n = 1;
        @(negedge clk);
        chk(tx_bit_ready === 1'b1, "R1", int'(tx_bit_ready), 1);
        chk(tx_chip_valid === 1'b0, "R1", int'(tx_chip_valid), 0);
        chk(rx_violation === 1'b0, "R1", int'(rx_violation), 0);

        // Single-stage runs
        run_case(4'b0001, 1, 1, 0, "R2");
        run_case(4'b0001, 0, 7, 0, "R2");
        run_case(4'b0010, 1, 2, 0, "R3");
        run_case(4'b0010, 2, 2, 0, "R3");
        run_case(4'b0100, 2, 3, 0, "R4");
        run_case(4'b1000, 0, 4, 0, "R5");
        run_case(4'b1111, 0, 5, 0, "R6");
        run_case(4'b0111, 1, 6, 0, "R6");

        // Full sweep of all configurations
        for (int c = 0; c < 16; c++) begin
            run_case(c[3:0], 0, 100 + c, 0, "R7");
            run_case(c[3:0], 2, 200 + c, 0, "R7");
        end

        // Line corruption cases
        run_case(4'b1000, 0, 11, 1, "R9");
        run_case(4'b0010, 0, 12, 1, "R10");
        run_case(4'b0001, 0, 13, 2, "R11");

        // R8: Manchester violations, driven by hand
        @(negedge clk); rst_n = 0;
        {cfg_manch, cfg_invert, cfg_diff, cfg_scramble} = 4'b1000;
        lb_en = 0; flip_mode = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        drive_pair(1'b1, 1'b1, 1'b1, 1'b1);
        drive_pair(1'b0, 1'b0, 1'b0, 1'b1);
        drive_pair(1'b1, 1'b0, 1'b1, 1'b0);
        drive_pair(1'b0, 1'b1, 1'b0, 1'b0);

        done = 1;
        summary();
        $finish;
    end
endmodule